// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block sits at the home node of a distributed shared-memory machine and keeps the coherence record for the memory lines that live there. It does not snoop. Remote caches send it request messages, and it answers each one with point-to-point messages aimed only at the nodes involved. For each line it records whether the line is unused, shared or held exclusively, which nodes hold a copy (one bit per node), and whether the exclusive copy has been modified. The home copy of the data for each line is held in a small local store.

Requests arrive on a valid/ready port. Each carries a kind, the requesting node and the line index, and a writeback also carries data. Outgoing messages leave on a second valid/ready port, one per accepted handshake.

The controller serves one transaction at a time. While a write is waiting for invalidation acknowledgements, every other request is held off by deasserting ready. The only exception is an acknowledgement for the line being written.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no message is offered (msg_valid low), req_ready is high, and every line is unused with home data zero.
- R2: A read (req_type 0) to an unused line sends an exclusive-data reply (msg_type 0) to the requester. The requester becomes the only holder, and the line becomes exclusive and clean.
- R3: A read to a shared line sends a shared-data reply (msg_type 1) to the requester and adds it to the holder set.
- R4: A read by another node to a clean exclusive line first sends a share notice (msg_type 2) to the owner, then a shared-data reply to the requester. The line becomes shared by both.
- R5: A read by another node to a modified exclusive line sends only a forward (msg_type 3) to the owner, with msg_aux naming the requester. The line becomes shared, clean, and held by both nodes.
- R6: A write (req_type 1) sends one invalidate (msg_type 4) to each recorded holder other than the writer, in ascending node order, and to no other node.
- R7: A write is answered with a grant (msg_type 5) to the writer only after as many acknowledgements (req_type 3, same line) have been accepted as invalidates were due. The line then becomes exclusive and modified, with the writer as sole holder.
- R8: While a transaction is in progress, req_ready is low for every request except an acknowledgement for the busy line while acknowledgements are still due.
- R9: A writeback (req_type 2) stores req_data as the line's home data, clears the modified flag, leaves the state and holders unchanged, and is answered with a writeback acknowledgement (msg_type 6) carrying the stored data.
- R10: A read by the current exclusive owner is answered with an exclusive-data reply and changes nothing.
- R11: While msg_valid is high and msg_ready is low, the offered message stays valid and unchanged.
- R12: An acknowledgement received while idle is accepted and has no effect on any line.
- R13: Every message carries the line index in msg_line, the requesting node in msg_aux, and the line's current home data in msg_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_type | input | 2 | 0 read, 1 write, 2 writeback, 3 invalidate acknowledgement |
| req_src | input | $clog2(NODES) | Requesting node |
| req_line | input | $clog2(LINES) | Line index |
| req_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken this cycle |
| msg_type | output | 3 | Message kind (0..6 as in the requirements) |
| msg_dst | output | $clog2(NODES) | Destination node |
| msg_line | output | $clog2(LINES) | Line index |
| msg_aux | output | $clog2(NODES) | Node whose request caused the message |
| msg_data | output | DATA_W | Home data of the line |

## Verification
The bench builds the controller with its defaults: 8 nodes, 16 lines and 32-bit data. With 8 nodes, a write can face up to seven holders, so invalidation fan-out, ascending ordering and out-of-order acknowledgements are all in reach. Sixteen lines are enough to probe back-pressure against a different, idle line while one line is busy. A random phase confined to four lines drives the lines repeatedly through every state transition, with the output port stalled every third cycle.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        LS_UNUSED = 2'd0,
        LS_SHARED = 2'd1,
        LS_EXCL   = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        RQ_READ   = 2'd0,
        RQ_WRITE  = 2'd1,
        RQ_WBACK  = 2'd2,
        RQ_INVACK = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        MS_DATA_EXCL  = 3'd0,
        MS_DATA_SHR   = 3'd1,
        MS_SHARE_NOTE = 3'd2,
        MS_FORWARD    = 3'd3,
        MS_INVAL      = 3'd4,
        MS_GRANT      = 3'd5,
        MS_WB_ACK     = 3'd6
    } msg_kind_e;

    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,
        FS_NOTE = 3'd1,
        FS_FWD  = 3'd2,
        FS_INV  = 3'd3,
        FS_WAIT = 3'd4,
        FS_RESP = 3'd5
    } fsm_e;

endpackage

// File: rtl/dir_bit_scan.sv
module dir_bit_scan #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] first,
    output logic [CW-1:0] count
);

    always_comb begin
        first = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) first = IW'(i);
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/dir_line_store.sv
module dir_line_store
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_addr,
    output line_state_e       rd_state,
    output logic [NODES-1:0]  rd_holders,
    output logic              rd_dirty,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LINE_W-1:0] wr_addr,
    input  logic              ent_we,
    input  line_state_e       wr_state,
    input  logic [NODES-1:0]  wr_holders,
    input  logic              wr_dirty,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] wr_data
);

    line_state_e       state_q   [LINES];
    line_state_e       state_d   [LINES];
    logic [NODES-1:0]  holders_q [LINES];
    logic [NODES-1:0]  holders_d [LINES];
    logic              dirty_q   [LINES];
    logic              dirty_d   [LINES];
    logic [DATA_W-1:0] data_q    [LINES];
    logic [DATA_W-1:0] data_d    [LINES];

    assign rd_state   = state_q[rd_addr];
    assign rd_holders = holders_q[rd_addr];
    assign rd_dirty   = dirty_q[rd_addr];
    assign rd_data    = data_q[rd_addr];

    always_comb begin
        state_d   = state_q;
        holders_d = holders_q;
        dirty_d   = dirty_q;
        data_d    = data_q;
        if (ent_we) begin
            state_d[wr_addr]   = wr_state;
            holders_d[wr_addr] = wr_holders;
            dirty_d[wr_addr]   = wr_dirty;
        end
        if (dat_we) begin
            data_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                state_q[i]   <= LS_UNUSED;
                holders_q[i] <= '0;
                dirty_q[i]   <= 1'b0;
                data_q[i]    <= '0;
            end
        end else begin
            state_q   <= state_d;
            holders_q <= holders_d;
            dirty_q   <= dirty_d;
            data_q    <= data_d;
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [ID_W-1:0]   req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [2:0]        msg_type,
    output logic [ID_W-1:0]   msg_dst,
    output logic [LINE_W-1:0] msg_line,
    output logic [ID_W-1:0]   msg_aux,
    output logic [DATA_W-1:0] msg_data
);

    localparam int CW = $clog2(NODES + 1);

    typedef struct packed {
        fsm_e              fsm;
        logic [ID_W-1:0]   src;
        logic [ID_W-1:0]   owner;
        logic [LINE_W-1:0] line;
        msg_kind_e         resp;
        logic [NODES-1:0]  inv;
        logic [CW-1:0]     pend;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    line_state_e       rd_state;
    logic [NODES-1:0]  rd_holders;
    logic              rd_dirty;
    logic [DATA_W-1:0] rd_data;
    logic [LINE_W-1:0] rd_addr;

    logic              ent_we;
    line_state_e       wr_state;
    logic [NODES-1:0]  wr_holders;
    logic              wr_dirty;
    logic              dat_we;

    logic [ID_W-1:0]   own_first;
    logic [CW-1:0]     own_cnt;
    logic [ID_W-1:0]   inv_first;
    logic [CW-1:0]     inv_cnt_unused;
    logic [NODES-1:0]  wr_mask;
    logic [ID_W-1:0]   wr_mask_first_unused;
    logic [CW-1:0]     wr_mask_cnt;

    logic [NODES-1:0]  src_bit;
    req_kind_e         kind;

    assign rd_addr = (ctl_q.fsm == FS_IDLE) ? req_line : ctl_q.line;
    assign src_bit = NODES'(1) << req_src;
    assign kind    = req_kind_e'(req_type);
    assign wr_mask = rd_holders & ~src_bit;

    dir_line_store #(
        .NODES (NODES),
        .LINES (LINES),
        .DATA_W(DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_state  (rd_state),
        .rd_holders(rd_holders),
        .rd_dirty  (rd_dirty),
        .rd_data   (rd_data),
        .wr_addr   (req_line),
        .ent_we    (ent_we),
        .wr_state  (wr_state),
        .wr_holders(wr_holders),
        .wr_dirty  (wr_dirty),
        .dat_we    (dat_we),
        .wr_data   (req_data)
    );

    dir_bit_scan #(.W(NODES)) u_owner_scan (
        .vec  (rd_holders),
        .first(own_first),
        .count(own_cnt)
    );

    dir_bit_scan #(.W(NODES)) u_inv_scan (
        .vec  (ctl_q.inv),
        .first(inv_first),
        .count(inv_cnt_unused)
    );

    dir_bit_scan #(.W(NODES)) u_mask_scan (
        .vec  (wr_mask),
        .first(wr_mask_first_unused),
        .count(wr_mask_cnt)
    );

    always_comb begin
        ctl_d      = ctl_q;
        req_ready  = 1'b0;
        ent_we     = 1'b0;
        dat_we     = 1'b0;
        wr_state   = rd_state;
        wr_holders = rd_holders;
        wr_dirty   = rd_dirty;
        msg_valid  = 1'b0;
        msg_type   = 3'(ctl_q.resp);
        msg_dst    = ctl_q.src;

        // acknowledgements are taken while a write waits on them
        if (ctl_q.fsm == FS_INV || ctl_q.fsm == FS_WAIT) begin
            req_ready = (kind == RQ_INVACK) && (req_line == ctl_q.line) &&
                        (ctl_q.pend != '0);
            if (req_valid && req_ready) begin
                ctl_d.pend = ctl_q.pend - CW'(1);
            end
        end

        unique case (ctl_q.fsm)
            FS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.src  = req_src;
                    ctl_d.line = req_line;
                    unique case (kind)
                        RQ_READ: begin
                            if (rd_state == LS_UNUSED) begin
                                ent_we     = 1'b1;
                                wr_state   = LS_EXCL;
                                wr_holders = src_bit;
                                wr_dirty   = 1'b0;
                                ctl_d.resp = MS_DATA_EXCL;
                                ctl_d.fsm  = FS_RESP;
                            end else if (rd_state == LS_SHARED) begin
                                ent_we     = 1'b1;
                                wr_holders = rd_holders | src_bit;
                                ctl_d.resp = MS_DATA_SHR;
                                ctl_d.fsm  = FS_RESP;
                            end else if (own_first == req_src) begin
                                ctl_d.resp = MS_DATA_EXCL;
                                ctl_d.fsm  = FS_RESP;
                            end else begin
                                ent_we      = 1'b1;
                                wr_state    = LS_SHARED;
                                wr_holders  = rd_holders | src_bit;
                                wr_dirty    = 1'b0;
                                ctl_d.owner = own_first;
                                ctl_d.resp  = MS_DATA_SHR;
                                ctl_d.fsm   = rd_dirty ? FS_FWD : FS_NOTE;
                            end
                        end
                        RQ_WRITE: begin
                            ent_we     = 1'b1;
                            wr_state   = LS_EXCL;
                            wr_holders = src_bit;
                            wr_dirty   = 1'b1;
                            ctl_d.inv  = wr_mask;
                            ctl_d.pend = wr_mask_cnt;
                            ctl_d.resp = MS_GRANT;
                            ctl_d.fsm  = (wr_mask == '0) ? FS_RESP : FS_INV;
                        end
                        RQ_WBACK: begin
                            ent_we     = 1'b1;
                            dat_we     = 1'b1;
                            wr_dirty   = 1'b0;
                            ctl_d.resp = MS_WB_ACK;
                            ctl_d.fsm  = FS_RESP;
                        end
                        default: begin
                            // stray acknowledgement: taken and dropped
                        end
                    endcase
                end
            end
            FS_NOTE: begin
                msg_valid = 1'b1;
                msg_type  = 3'(MS_SHARE_NOTE);
                msg_dst   = ctl_q.owner;
                if (msg_ready) ctl_d.fsm = FS_RESP;
            end
            FS_FWD: begin
                msg_valid = 1'b1;
                msg_type  = 3'(MS_FORWARD);
                msg_dst   = ctl_q.owner;
                if (msg_ready) ctl_d.fsm = FS_IDLE;
            end
            FS_INV: begin
                msg_valid = 1'b1;
                msg_type  = 3'(MS_INVAL);
                msg_dst   = inv_first;
                if (msg_ready) begin
                    ctl_d.inv = ctl_q.inv & ~(NODES'(1) << inv_first);
                    if (ctl_d.inv == '0) ctl_d.fsm = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (ctl_d.pend == '0) ctl_d.fsm = FS_RESP;
            end
            FS_RESP: begin
                msg_valid = 1'b1;
                if (msg_ready) ctl_d.fsm = FS_IDLE;
            end
            default: ctl_d.fsm = FS_IDLE;
        endcase
    end

    assign msg_line = ctl_q.line;
    assign msg_aux  = ctl_q.src;
    assign msg_data = rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) &&
        $stable(msg_dst) && $stable(msg_data) && $stable(msg_line)) else $error("hold"); // R11

    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.fsm != FS_IDLE && req_type != 2'(RQ_INVACK) |-> !req_ready) else $error("busy"); // R8

    AST_GRANT_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_type == 3'(MS_GRANT) |-> ctl_q.pend == '0) else $error("grant"); // R7

    AST_INV_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_type == 3'(MS_INVAL) |-> ctl_q.inv[msg_dst]) else $error("inv target"); // R6

    AST_INV_ONE_EACH: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && msg_type == 3'(MS_INVAL) |=>
        $countones(ctl_q.inv) + 1 == $countones($past(ctl_q.inv))) else $error("inv count"); // R6

    AST_EXCL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.fsm == FS_IDLE && rd_state == LS_EXCL |-> own_cnt == CW'(1)) else $error("owner"); // R2

endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;

    localparam int NODES = 8;
    localparam int LINES = 16;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0]  req_type = '0;
    logic [2:0]  req_src = '0;
    logic [3:0]  req_line = '0;
    logic [31:0] req_data = '0;
    logic msg_valid;
    logic msg_ready = 1'b0;
    logic [2:0]  msg_type;
    logic [2:0]  msg_dst;
    logic [3:0]  msg_line;
    logic [2:0]  msg_aux;
    logic [31:0] msg_data;

    always #5 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
        .msg_dst(msg_dst), .msg_line(msg_line), .msg_aux(msg_aux), .msg_data(msg_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_tag = "R13";

    // reference model
    int          st_m   [LINES];
    logic [7:0]  hold_m [LINES];
    bit          dirty_m[LINES];
    logic [31:0] mem_m  [LINES];
    logic [44:0] exp_q[$];
    logic [7:0]  last_mask;
    int acks_needed = 0;
    int acks_done = 0;

    function automatic logic [44:0] pk(int t, int d, int l, int a, logic [31:0] v);
        return {3'(t), 3'(d), 4'(l), 3'(a), v};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void model_accept(int k, int s, int l, logic [31:0] d);
        int owner;
        logic [7:0] sb;
        sb = 8'(1) << s;
        owner = 0;
        for (int i = NODES - 1; i >= 0; i--) if (hold_m[l][i]) owner = i;
        case (k)
            0: begin
                if (st_m[l] == 0) begin
                    exp_q.push_back(pk(0, s, l, s, mem_m[l]));
                    st_m[l] = 2; hold_m[l] = sb; dirty_m[l] = 0;
                end else if (st_m[l] == 1) begin
                    exp_q.push_back(pk(1, s, l, s, mem_m[l]));
                    hold_m[l] |= sb;
                end else if (owner == s) begin
                    exp_q.push_back(pk(0, s, l, s, mem_m[l]));
                end else begin
                    if (dirty_m[l]) exp_q.push_back(pk(3, owner, l, s, mem_m[l]));
                    else begin
                        exp_q.push_back(pk(2, owner, l, s, mem_m[l]));
                        exp_q.push_back(pk(1, s, l, s, mem_m[l]));
                    end
                    st_m[l] = 1; hold_m[l] |= sb; dirty_m[l] = 0;
                end
            end
            1: begin
                last_mask = hold_m[l] & ~sb;
                acks_needed = 0;
                acks_done = 0;
                for (int i = 0; i < NODES; i++) if (last_mask[i]) begin
                    exp_q.push_back(pk(4, i, l, s, mem_m[l]));
                    acks_needed++;
                end
                exp_q.push_back(pk(5, s, l, s, mem_m[l]));
                st_m[l] = 2; hold_m[l] = sb; dirty_m[l] = 1;
            end
            2: begin
                mem_m[l] = d; dirty_m[l] = 0;
                exp_q.push_back(pk(6, s, l, s, d));
            end
            default: if (st_m[l] != 0 || st_m[l] == 0) acks_done++;
        endcase
    endfunction

    task automatic send(int k, int s, int l, logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_type = 2'(k); req_src = 3'(s);
        req_line = 4'(l); req_data = d;
        forever begin
            @(negedge clk);
            if (req_ready) begin
                model_accept(k, s, l, d);
                break;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send_acks(int l);
        logic [7:0] m;
        m = last_mask;
        for (int i = NODES - 1; i >= 0; i--) if (m[i]) send(3, i, l, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, cur_tag, "pending expected messages", 64'(exp_q.size()), 0);
    endtask

    // output port stalls every third cycle
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 msg_ready <= (cyc % 3) != 1;
    end

    // monitor: compare every transfer against the model, check holds
    logic        prev_stall = 1'b0;
    logic [44:0] prev_msg;
    always @(negedge clk) begin
        logic [44:0] got;
        logic [44:0] e;
        got = {msg_type, msg_dst, msg_line, msg_aux, msg_data};
        if (rst_n) begin
            if (prev_stall)
                chk(msg_valid && got == prev_msg, "R11", "stalled message changed",
                    64'(got), 64'(prev_msg));
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected message", 64'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, cur_tag, "message", 64'(got), 64'(e));
                    if (msg_type == 3'd5)
                        chk(acks_done == acks_needed, "R7", "grant before all acks",
                            64'(acks_done), 64'(acks_needed));
                end
            end
            prev_stall = msg_valid && !msg_ready;
            prev_msg = got;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        chk(1'b0, "R13", "watchdog expired", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            st_m[i] = 0; hold_m[i] = '0; dirty_m[i] = 0; mem_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);
        chk(msg_valid == 1'b0, "R1", "no message after reset", 64'(msg_valid), 0);

        cur_tag = "R2";  send(0, 2, 3, 0); drain();          // R1 R2: unused read, data 0
        cur_tag = "R10"; send(0, 2, 3, 0); drain();          // owner re-read
        cur_tag = "R4";  send(0, 5, 3, 0); drain();          // clean exclusive, other reader
        cur_tag = "R3";  send(0, 7, 3, 0); drain();          // shared read

        cur_tag = "R6";  send(1, 5, 3, 0);                   // invalidate 2 and 7
        @(posedge clk); #1;
        req_valid = 1'b1; req_type = 2'd0; req_src = 3'd1; req_line = 4'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R8", "read to busy line accepted", 64'(req_ready), 0);
        end
        @(posedge clk); #1;
        req_type = 2'd3; req_line = 4'd4;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8", "ack for other line accepted", 64'(req_ready), 0);
        @(posedge clk); #1;
        req_type = 2'd2; req_line = 4'd9;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8", "writeback to idle line accepted", 64'(req_ready), 0);
        @(posedge clk); #1 req_valid = 1'b0;
        cur_tag = "R7"; send_acks(3); drain();

        cur_tag = "R9"; send(2, 5, 3, 32'hCAFE_0123); drain();
        cur_tag = "R4"; send(0, 1, 3, 0); drain();           // clean after writeback

        cur_tag = "R7"; send(1, 0, 6, 0); drain();           // no holders: immediate grant
        cur_tag = "R5"; send(0, 4, 6, 0); drain();           // dirty: forward to 0
        cur_tag = "R5"; send(0, 3, 6, 0); drain();           // now shared and clean
        cur_tag = "R12"; send(3, 3, 6, 0); send(0, 1, 6, 0); drain();
        cur_tag = "R6"; send(1, 3, 6, 0); send_acks(6); drain();

        cur_tag = "R13";
        for (int n = 0; n < 60; n++) begin
            int k, s, l;
            k = $urandom_range(0, 2);
            s = $urandom_range(0, NODES - 1);
            l = $urandom_range(0, 3);
            send(k, s, l, $urandom);
            if (k == 1) send_acks(l);
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule